// File: doc/BRIEF.md
# Power-State Clock Source Selector

This block holds a 32-bit clock policy word. The top nibble of the word gives the current power state, and the rest holds one 4-bit source field for each state. The block decodes the state from the nibble by priority and picks the source field that belongs to that state. It then drives a registered source index to a downstream clock multiplexer. When the block is built with the halving option, a virtual "high-PLL divided by two" source exists. It is encoded as the high-PLL field value with a separate bypass bit cleared. The block reports that source as its own index and raises a divide-by-two enable for it.

Software can write the whole word and read it back. A set-source request port changes only the field that belongs to the current state, in a single cycle. The request handles the bypass bit when the virtual halved source or the real high-PLL source is asked for. A registered error flag is high whenever the decoded state is not one of the two operating states (RUN or IDLE) in which source selection is defined.

Top module: `pwr_src_select`

## Requirements
- R1: After reset the word reads 0x2000_0000, and `src_idx`, `div2_en`, `state_err` and `req_done` are all 0.
- R2: A cycle with `wr_en` high stores the full `wdata`. From the next cycle on, `rd_data` returns it, and `src_idx`, `div2_en` and `state_err` reflect it.
- R3: The state comes from bits 31:28. Bit 31 gives FIQ (4), bit 30 gives IRQ (3), bit 29 gives RUN (2) and bit 28 gives IDLE (1). The highest set bit wins. A zero nibble gives STANDBY (0).
- R4: Without the halving case, `src_idx` equals word[state*4 +: 4] zero-extended to 5 bits, for every state, legal or not.
- R5: `state_err` is 1 exactly when the decoded state is neither RUN (2) nor IDLE (1).
- R6: With the halving option (HAS_HALF=1), a selected field of 8 with bit 16 clear gives `src_idx` = 16 and `div2_en` = 1. In every other case `div2_en` is 0. With HAS_HALF=0, `div2_en` is always 0 and a field of 8 reports 8.
- R7: A request (`req_valid` high, `wr_en` low) for an index 0..15 in a legal state writes that index into the active field. It leaves all other bits unchanged, except in the case of R9. `req_done` is high for exactly the next cycle.
- R8: With HAS_HALF=1, a request for index 16 in a legal state clears bit 16 and writes 8 into the active field.
- R9: With HAS_HALF=1, a request for index 8 in a legal state sets bit 16 and writes 8 into the active field.
- R10: A request in an illegal state, or for an index above 15 that is not the halved source, leaves the word unchanged, but `req_done` still pulses.
- R11: When `wr_en` and `req_valid` are high in the same cycle, the write is stored, the request is dropped, and `req_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Stored policy word |
| req_valid | input | 1 | Set-source request strobe |
| req_idx | input | 5 | Requested source index |
| req_done | output | 1 | One-cycle acknowledge after a request |
| src_idx | output | 5 | Effective source index (16 = halved high PLL) |
| div2_en | output | 1 | Halving path enable |
| state_err | output | 1 | Decoded state is not RUN or IDLE |

## Verification
The assertions assume that `req_valid` and `wr_en` are single-cycle strobes, sampled at the rising edge. They also assume that a request is judged against the word held before that edge, so the expected word always follows from the value last read back. The bench drives all inputs on the falling edge and clears both strobes after each operation. It sweeps all 16 state nibbles against several field patterns, and it issues requests for all 32 indices from legal and illegal states. It also drives a second instance built without the halving option from the same inputs.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [2:0] {
        PS_STANDBY = 3'd0,
        PS_IDLE    = 3'd1,
        PS_RUN     = 3'd2,
        PS_IRQ     = 3'd3,
        PS_FIQ     = 3'd4
    } pstate_e;

    localparam int NUM_PSTATES = 5;
    localparam int NIB_W       = 4;
endpackage

// File: rtl/pss_state_decode.sv
module pss_state_decode
    import pss_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output pstate_e          state,
    output logic             legal
);
    always_comb begin
        if (nib[3])      state = PS_FIQ;
        else if (nib[2]) state = PS_IRQ;
        else if (nib[1]) state = PS_RUN;
        else if (nib[0]) state = PS_IDLE;
        else             state = PS_STANDBY;
        legal = (state == PS_RUN) || (state == PS_IDLE);
    end
endmodule

// File: rtl/pss_field_pick.sv
module pss_field_pick
    import pss_pkg::*;
#(
    parameter int FIELD_W  = 4,
    parameter bit HAS_HALF = 1'b1,
    parameter int HIGH_SRC = 8,
    localparam int IDX_W   = FIELD_W + 1,
    localparam int FLAT_W  = NUM_PSTATES * FIELD_W
) (
    input  logic [FLAT_W-1:0] fields_flat,
    input  logic              byp,
    input  pstate_e           state,
    output logic [IDX_W-1:0]  src_idx,
    output logic              div2_en
);
    localparam logic [FIELD_W-1:0] HIGH_F   = FIELD_W'(HIGH_SRC);
    localparam logic [IDX_W-1:0]   HALF_IDX = IDX_W'(1 << FIELD_W);

    logic [FIELD_W-1:0] fields [NUM_PSTATES];
    logic [FIELD_W-1:0] sel_field;

    for (genvar g = 0; g < NUM_PSTATES; g++) begin : g_split
        assign fields[g] = fields_flat[g*FIELD_W +: FIELD_W];
    end

    always_comb begin
        sel_field = '0;
        for (int k = 0; k < NUM_PSTATES; k++) begin
            if (int'(state) == k) sel_field = fields[k];
        end
    end

    if (HAS_HALF) begin : g_half
        logic fold;
        assign fold    = (sel_field == HIGH_F) && !byp;
        assign src_idx = fold ? HALF_IDX : IDX_W'(sel_field);
        assign div2_en = fold;
    end else begin : g_plain
        logic unused_byp;
        assign unused_byp = byp;
        assign src_idx    = IDX_W'(sel_field);
        assign div2_en    = 1'b0;
    end
endmodule

// File: rtl/pss_req_merge.sv
module pss_req_merge
    import pss_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int FIELD_W  = 4,
    parameter bit HAS_HALF = 1'b1,
    parameter int HIGH_SRC = 8,
    parameter int BYP_BIT  = 16,
    localparam int IDX_W   = FIELD_W + 1
) (
    input  logic [WORD_W-1:0] word,
    input  pstate_e           state,
    input  logic              legal,
    input  logic [IDX_W-1:0]  req_idx,
    output logic [WORD_W-1:0] merged
);
    localparam logic [FIELD_W-1:0] HIGH_F   = FIELD_W'(HIGH_SRC);
    localparam logic [IDX_W-1:0]   HIGH_IDX = IDX_W'(HIGH_SRC);
    localparam logic [IDX_W-1:0]   HALF_IDX = IDX_W'(1 << FIELD_W);

    int sh;

    always_comb begin
        merged = word;
        sh     = int'(state) * FIELD_W;
        if (legal) begin
            if (HAS_HALF && req_idx == HALF_IDX) begin
                merged[BYP_BIT]         = 1'b0;
                merged[sh +: FIELD_W]   = HIGH_F;
            end else if (HAS_HALF && req_idx == HIGH_IDX) begin
                merged[BYP_BIT]         = 1'b1;
                merged[sh +: FIELD_W]   = HIGH_F;
            end else if (!req_idx[IDX_W-1]) begin
                merged[sh +: FIELD_W]   = req_idx[FIELD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pwr_src_select.sv
module pwr_src_select
    import pss_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int FIELD_W  = 4,
    parameter bit HAS_HALF = 1'b1,
    parameter int HIGH_SRC = 8,
    parameter int BYP_BIT  = 16,
    parameter logic [WORD_W-1:0] RST_WORD = 32'h2000_0000,
    localparam int IDX_W   = FIELD_W + 1,
    localparam int FLAT_W  = NUM_PSTATES * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              req_done,
    output logic [IDX_W-1:0]  src_idx,
    output logic              div2_en,
    output logic              state_err
);
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(1 << FIELD_W);

    typedef struct packed {
        logic [WORD_W-1:0] policy;
        logic [IDX_W-1:0]  src;
        logic              div2;
        logic              err;
        logic              done;
    } regs_t;

    regs_t q, d;

    pstate_e           cur_state, nx_state;
    logic              cur_legal, nx_legal;
    logic [WORD_W-1:0] merged_word, policy_nx;
    logic [IDX_W-1:0]  nx_src;
    logic              nx_div2;

    pss_state_decode u_cur_dec (
        .nib   (q.policy[WORD_W-1 -: NIB_W]),
        .state (cur_state),
        .legal (cur_legal)
    );

    pss_req_merge #(
        .WORD_W(WORD_W), .FIELD_W(FIELD_W), .HAS_HALF(HAS_HALF),
        .HIGH_SRC(HIGH_SRC), .BYP_BIT(BYP_BIT)
    ) u_merge (
        .word    (q.policy),
        .state   (cur_state),
        .legal   (cur_legal),
        .req_idx (req_idx),
        .merged  (merged_word)
    );

    assign policy_nx = wr_en ? wdata : (req_valid ? merged_word : q.policy);

    pss_state_decode u_nx_dec (
        .nib   (policy_nx[WORD_W-1 -: NIB_W]),
        .state (nx_state),
        .legal (nx_legal)
    );

    pss_field_pick #(
        .FIELD_W(FIELD_W), .HAS_HALF(HAS_HALF), .HIGH_SRC(HIGH_SRC)
    ) u_pick (
        .fields_flat (policy_nx[FLAT_W-1:0]),
        .byp         (policy_nx[BYP_BIT]),
        .state       (nx_state),
        .src_idx     (nx_src),
        .div2_en     (nx_div2)
    );

    always_comb begin
        d        = q;
        d.policy = policy_nx;
        d.src    = nx_src;
        d.div2   = nx_div2;
        d.err    = !nx_legal;
        d.done   = req_valid && !wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.policy <= RST_WORD;
            q.src    <= '0;
            q.div2   <= 1'b0;
            q.err    <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data   = q.policy;
    assign src_idx   = q.src;
    assign div2_en   = q.div2;
    assign state_err = q.err;
    assign req_done  = q.done;

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wdata)); // R2
    AST_WRITE_BEATS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !req_done); // R11
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en) |=> req_done); // R7
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !wr_en) |=> !req_done); // R7
    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !wr_en && state_err) |=> $stable(rd_data)); // R10
    AST_HALF_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        div2_en |-> (!rd_data[BYP_BIT] && src_idx == HALF_IDX)); // R6
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        src_idx <= HALF_IDX); // R4
    AST_ERR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_err |-> (rd_data[WORD_W-1 -: 2] != 2'b00 || rd_data[WORD_W-1 -: NIB_W] == '0)); // R5
endmodule

// File: tb/pwr_src_select_bench.sv
`timescale 1ns/1ps
module pwr_src_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_idx = '0;
    logic [31:0] rd_a, rd_b;
    logic        done_a, done_b, div_a, div_b, err_a, err_b;
    logic [4:0]  src_a, src_b;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    pwr_src_select u_pwr_src_select (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_data(rd_a),
        .req_valid(req_valid), .req_idx(req_idx), .req_done(done_a),
        .src_idx(src_a), .div2_en(div_a), .state_err(err_a)
    );

    pwr_src_select #(.HAS_HALF(1'b0)) u_pwr_src_select_plain (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_data(rd_b),
        .req_valid(req_valid), .req_idx(req_idx), .req_done(done_b),
        .src_idx(src_b), .div2_en(div_b), .state_err(err_b)
    );

    function automatic int m_state(logic [31:0] w);
        if (w[31])      return 4;
        else if (w[30]) return 3;
        else if (w[29]) return 2;
        else if (w[28]) return 1;
        return 0;
    endfunction

    function automatic int m_field(logic [31:0] w);
        return int'((w >> (m_state(w) * 4)) & 32'hF);
    endfunction

    function automatic int m_src(logic [31:0] w, bit half);
        if (half && m_field(w) == 8 && !w[16]) return 16;
        return m_field(w);
    endfunction

    function automatic bit m_err(logic [31:0] w);
        return !(m_state(w) == 1 || m_state(w) == 2);
    endfunction

    function automatic logic [31:0] m_req(logic [31:0] w, int idx, bit half);
        logic [31:0] r;
        int sh;
        r  = w;
        sh = m_state(w) * 4;
        if (m_err(w)) return w;
        if (half && idx == 16) begin
            r[16] = 1'b0;
            r = (r & ~(32'hF << sh)) | (32'd8 << sh);
        end else if (half && idx == 8) begin
            r[16] = 1'b1;
            r = (r & ~(32'hF << sh)) | (32'd8 << sh);
        end else if (idx < 16) begin
            r = (r & ~(32'hF << sh)) | (32'(idx) << sh);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [31:0] w);
        chk({req, " word A"}, rd_a, w);
        chk({req, " word B"}, rd_b, w);
        chk({req, " src A (R4/R6)"}, 32'(src_a), 32'(m_src(w, 1'b1)));
        chk({req, " src B (R4)"}, 32'(src_b), 32'(m_src(w, 1'b0)));
        chk({req, " div2 A (R6)"}, 32'(div_a), 32'(m_src(w, 1'b1) == 16));
        chk({req, " div2 B (R6)"}, 32'(div_b), 32'd0);
        chk({req, " err A (R5)"}, 32'(err_a), 32'(m_err(w)));
        chk({req, " err B (R5)"}, 32'(err_b), 32'(m_err(w)));
    endtask

    task automatic do_write(logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] w, ea, eb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 word A", rd_a, 32'h2000_0000);
        chk("R1 src A", 32'(src_a), 0);
        chk("R1 div2 A", 32'(div_a), 0);
        chk("R1 err A", 32'(err_a), 0);
        chk("R1 done A", 32'(done_a), 0);

        // R2 R3 R4 R5 R6: sweep all nibbles against field patterns
        for (int nib = 0; nib < 16; nib++) begin
            for (int p = 0; p < 18; p++) begin
                if (p < 16) w = {4'(nib), 8'hA5, 4'(p + 4), 4'(p + 3), 4'(p + 2), 4'(p + 1), 4'(p)};
                else        w = {4'(nib), 8'h00, 4'((p == 16) ? 8 : 9), 4'd8, 4'd8, 4'd8, 4'd8};
                do_write(w);
                check_all("R2/R3 sweep", w);
            end
        end

        // R7 R8 R9 R10: requests from each state kind for all indices
        for (int s = 0; s < 6; s++) begin
            for (int idx = 0; idx < 32; idx++) begin
                logic [3:0] nib;
                case (s)
                    0: nib = 4'b0001;
                    1: nib = 4'b0010;
                    2: nib = 4'b0011;
                    3: nib = 4'b0000;
                    4: nib = 4'b0100;
                    default: nib = 4'b1010;
                endcase
                w = {nib, 12'h3C3, 16'h5A5A} ^ 32'(idx * 32'h0001_1111);
                w[31:28] = nib;
                do_write(w);
                @(negedge clk);
                req_valid = 1'b1; req_idx = 5'(idx);
                @(negedge clk);
                req_valid = 1'b0;
                ea = m_req(w, idx, 1'b1);
                eb = m_req(w, idx, 1'b0);
                chk("R7 done A", 32'(done_a), 1);
                chk("R7 done B", 32'(done_b), 1);
                chk("R8/R9/R10 req word A", rd_a, ea);
                chk("R7/R10 req word B", rd_b, eb);
                chk("R6 src A after req", 32'(src_a), 32'(m_src(ea, 1'b1)));
                chk("R4 src B after req", 32'(src_b), 32'(m_src(eb, 1'b0)));
                @(negedge clk);
                chk("R7 done single cycle", 32'(done_a), 0);
            end
        end

        // R11 write and request together
        do_write(32'h2000_0300);
        @(negedge clk);
        wr_en = 1'b1; wdata = 32'h1000_0070; req_valid = 1'b1; req_idx = 5'd16;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R11 write wins A", rd_a, 32'h1000_0070);
        chk("R11 no done A", 32'(done_a), 0);
        chk("R11 no done B", 32'(done_b), 0);
        check_all("R11", 32'h1000_0070);

        finish_run();
    end
endmodule